// File: doc/BRIEF.md
# Disk Host-Interface Register File (Device Side)

This block sits on the device side of a parallel disk host bus. It takes single-cycle host register accesses, each with two active-low block selects and a 3-bit register address. It holds the command parameters that the host programs: feature, sector count, a 28-bit block address and a device/head byte. It also holds the control byte and the status, error and interrupt state. Several addresses reach a different register for a read than for a write. Error and feature share an address, and so do status and command. Alternate status shares an address with the control byte.

When the host writes the command register, the device core receives a one-cycle opcode pulse and the block turns busy. The core reports completion with a done pulse, a fail flag and an error code. That clears busy and raises a pending interrupt. A read of the status register clears the pending interrupt. A read of alternate status returns the same byte and leaves the interrupt alone. The data port is passed straight through to the core as a 16-bit write stream and a 16-bit read stream. A strap input sets whether this block answers as device 0 or device 1. A control bit holds the whole block in soft reset.

Top module: `ata_taskfile_regs`

## Requirements
- R1: An access is sampled on a clock edge where `acc_valid` is high. Read data appears on `rdata` after that edge and holds until the next read. With `cmdblk_sel_n`=0 and `ctlblk_sel_n`=1, `reg_addr` selects the following: 0 is the data port, 1 is error (read) or feature (write), 2 is sector count, 3 is block address bits 7:0, 4 is bits 15:8, 5 is bits 23:16, 6 is device/head (its bits 3:0 are block address bits 27:24), and 7 is status (read) or command (write). All registers other than the data port store only `wdata[7:0]` and read back with bits 15:8 zero.
- R2: With `ctlblk_sel_n`=0 and `cmdblk_sel_n`=1, address 6 is alternate status (read) or the control byte (write). A read of address 7 returns the drive-address byte {2'b11, ~head[3:0], ~dev_id_strap, dev_id_strap}, and a write to address 7 has no effect. Any other combination of selects, and any other control-block address, reads 0.
- R3: A read at address 1 returns the error register, not the value last written as feature.
- R4: The block is selected when bit 4 of device/head equals `dev_id_strap`. While it is not selected, every read returns 0, command and data-port writes are ignored, a status read does not clear the pending interrupt, and `irq_out` is low. Writes to the other registers are still stored.
- R5: The status byte has busy in bit 7 and ready in bit 6, which is 1 unless soft reset is active. Data request is in bit 3 and equals `core_drq` while not busy. Error is in bit 0. All other bits are 0.
- R6: An accepted command write drives `cmd_valid` high for exactly one cycle after the edge, with `cmd_opcode` equal to `wdata[7:0]`. The same write sets busy, clears error and clears the pending interrupt.
- R7: While busy, writes to addresses 1 to 7 of the command block are ignored. Control-byte writes are always accepted.
- R8: A `core_done` pulse while busy does four things. It clears busy, sets error to `core_err`, loads the error register with `core_err_code` when `core_err` is 1 (else 0x00), and sets the pending interrupt. A `core_done` pulse while not busy changes nothing.
- R9: `irq_out` is registered. It equals pending AND NOT mask AND selected, where mask is control-byte bit 1, all as they stood one cycle earlier. It rises on the second edge after the `core_done` edge.
- R10: A selected status read clears the pending interrupt, so `irq_out` falls one edge later. An alternate-status read leaves the pending interrupt unchanged.
- R11: Control-byte bit 2 is soft reset, and `soft_reset_out` follows it. While it is set, status reads 0x80: busy is set, ready is clear and the pending interrupt is clear. The task-file registers are also held at their reset values. After the bit is cleared, busy drops on the second edge.
- R12: A selected data-port write pulses `dport_wr_valid` for one cycle with `dport_wr_data`=`wdata`. A selected data-port read returns `dport_rd_data` and pulses `dport_rd_req`. Busy does not block the data port.
- R13: After `rst` the values are: sector count 0x01, address bits 7:0 0x01, error 0x01, status 0x40, feature, the other address bytes and device/head 0x00, and `irq_out`, `cmd_valid` and `soft_reset_out` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| ctlblk_sel_n | input | 1 | Active-low control-block select |
| cmdblk_sel_n | input | 1 | Active-low command-block select |
| reg_addr | input | 3 | Register address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered read data |
| dev_id_strap | input | 1 | 0 = answer as device 0, 1 = device 1 |
| cmd_valid | output | 1 | One-cycle command pulse to the core |
| cmd_opcode | output | 8 | Command opcode |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count register |
| tf_lba | output | 28 | Block address / geometry bytes |
| core_done | input | 1 | Command completion pulse |
| core_err | input | 1 | Completion with error |
| core_err_code | input | 8 | Error register value on failure |
| core_drq | input | 1 | Core is ready for a data transfer |
| soft_reset_out | output | 1 | Soft reset level to the core |
| irq_out | output | 1 | Active-high interrupt request |
| dport_wr_valid | output | 1 | Data-port write pulse |
| dport_wr_data | output | 16 | Data-port write word |
| dport_rd_req | output | 1 | Data-port read pop pulse |
| dport_rd_data | input | 16 | Data-port read word |

## Verification
The bench targets the shared addresses, where a design that muxed by address alone would echo the feature value on an error read or treat a status read as a command. It compares status and alternate-status reads on a pending interrupt. A design that cleared on both reads would drop `irq_out` too early, and one that cleared on neither would leave it stuck high. It also probes writes while busy and commands while deselected, either of which would produce a stray opcode pulse or overwrite parameters. Soft reset is checked both for holding the registers and for releasing busy afterwards.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_ERRFEAT, SEL_COUNT, SEL_LBA0, SEL_LBA1,
    SEL_LBA2, SEL_DEVHEAD, SEL_STATCMD, SEL_ALTCTL, SEL_DRVADDR
  } tf_sel_e;

  localparam int unsigned ST_BUSY  = 7;
  localparam int unsigned ST_READY = 6;
  localparam int unsigned ST_DREQ  = 3;
  localparam int unsigned ST_ERR   = 0;
  localparam int unsigned CTL_SOFT_RESET = 2;
  localparam int unsigned CTL_IRQ_MASK   = 1;
  localparam int unsigned DH_DEVBIT      = 4;
  localparam int unsigned NUM_TF_REGS    = 6;
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              ctlblk_sel_n,
  input  logic              cmdblk_sel_n,
  input  logic [ADDR_W-1:0] reg_addr,
  output tf_sel_e           sel
);
  always_comb begin
    sel = SEL_NONE;
    if (ctlblk_sel_n && !cmdblk_sel_n) begin
      case (reg_addr)
        3'd0: sel = SEL_DATA;
        3'd1: sel = SEL_ERRFEAT;
        3'd2: sel = SEL_COUNT;
        3'd3: sel = SEL_LBA0;
        3'd4: sel = SEL_LBA1;
        3'd5: sel = SEL_LBA2;
        3'd6: sel = SEL_DEVHEAD;
        default: sel = SEL_STATCMD;
      endcase
    end else if (!ctlblk_sel_n && cmdblk_sel_n) begin
      if (reg_addr == 3'd6)      sel = SEL_ALTCTL;
      else if (reg_addr == 3'd7) sel = SEL_DRVADDR;
    end
  end
endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hold,
  input  logic                         wr_en,
  input  tf_sel_e                      sel,
  input  logic [REG_W-1:0]             wdata,
  output logic [NUM_TF_REGS*REG_W-1:0] regs_flat
);
  // slot order follows the enum: feature, count, lba0, lba1, lba2, devhead
  function automatic logic [REG_W-1:0] rst_val(input int idx);
    return (idx == 1 || idx == 2) ? REG_W'(1) : '0;
  endfunction

  for (genvar i = 0; i < NUM_TF_REGS; i++) begin : g_reg
    localparam logic [3:0] CODE = 4'(int'(SEL_ERRFEAT) + i);
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || hold)
        q <= rst_val(i);
      else if (wr_en && sel == tf_sel_e'(CODE))
        q <= wdata;
    end
    assign regs_flat[i*REG_W +: REG_W] = q;
  end
endmodule

// File: rtl/ata_tf_status.sv
module ata_tf_status #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_reset,
  input  logic             cmd_go,
  input  logic             done,
  input  logic             done_err,
  input  logic [REG_W-1:0] done_code,
  input  logic             status_rd,
  input  logic             irq_mask,
  input  logic             selected,
  output logic             busy,
  output logic             err,
  output logic             pend,
  output logic             irq,
  output logic [REG_W-1:0] err_reg
);
  localparam logic [REG_W-1:0] ERR_DIAG = REG_W'(1);
  logic soft_reset_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; err <= 1'b0; pend <= 1'b0; irq <= 1'b0;
      err_reg <= ERR_DIAG; soft_reset_q <= 1'b0;
    end else begin
      soft_reset_q <= soft_reset;
      irq <= pend & ~irq_mask & selected;
      if (soft_reset) begin
        busy <= 1'b1; err <= 1'b0; pend <= 1'b0; irq <= 1'b0;
        err_reg <= ERR_DIAG;
      end else if (soft_reset_q) begin
        busy <= 1'b0;
      end else if (cmd_go) begin
        busy <= 1'b1; err <= 1'b0; pend <= 1'b0;
      end else if (done && busy) begin
        busy <= 1'b0; err <= done_err; pend <= 1'b1;
        err_reg <= done_err ? done_code : '0;
      end else if (status_rd) begin
        pend <= 1'b0;
      end
    end
  end

  assert_cmd_sets_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && !soft_reset && !soft_reset_q) |=> (busy && !err && !pend));
  assert_status_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !done && !soft_reset) |=> !pend);
  assert_soft_reset_busy_R11: assert property (@(posedge clk) disable iff (rst)
    soft_reset |=> (busy && !pend && !irq));
  assert_done_idle_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !busy && !cmd_go && !soft_reset && !soft_reset_q) |=> ($stable(err) && $stable(err_reg)));
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs #(
  parameter int DATA_W = 16,
  parameter int REG_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               ctlblk_sel_n,
  input  logic               cmdblk_sel_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               dev_id_strap,
  output logic               cmd_valid,
  output logic [REG_W-1:0]   cmd_opcode,
  output logic [REG_W-1:0]   tf_feature,
  output logic [REG_W-1:0]   tf_count,
  output logic [3*REG_W+3:0] tf_lba,
  input  logic               core_done,
  input  logic               core_err,
  input  logic [REG_W-1:0]   core_err_code,
  input  logic               core_drq,
  output logic               soft_reset_out,
  output logic               irq_out,
  output logic               dport_wr_valid,
  output logic [DATA_W-1:0]  dport_wr_data,
  output logic               dport_rd_req,
  input  logic [DATA_W-1:0]  dport_rd_data
);
  import ata_tf_pkg::*;

  tf_sel_e sel;
  logic [NUM_TF_REGS*REG_W-1:0] regs_flat;
  logic [REG_W-1:0] r_lba0, r_lba1, r_lba2, r_devhead, status_byte, drvaddr, err_reg;
  logic busy, err, pend, irq_mask_q;
  logic wr, rd, selected, cmd_go, status_rd;
  logic [DATA_W-1:0] rd_mux;

  ata_tf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .ctlblk_sel_n(ctlblk_sel_n), .cmdblk_sel_n(cmdblk_sel_n),
    .reg_addr(reg_addr), .sel(sel));

  assign wr        = acc_valid & acc_write;
  assign rd        = acc_valid & ~acc_write;
  assign selected  = (r_devhead[DH_DEVBIT] == dev_id_strap);
  assign cmd_go    = wr && sel == SEL_STATCMD && !busy && selected;
  assign status_rd = rd && sel == SEL_STATCMD && selected;

  ata_tf_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .hold(soft_reset_out), .wr_en(wr && !busy),
    .sel(sel), .wdata(wdata[REG_W-1:0]), .regs_flat(regs_flat));

  assign tf_feature = regs_flat[0*REG_W +: REG_W];
  assign tf_count   = regs_flat[1*REG_W +: REG_W];
  assign r_lba0     = regs_flat[2*REG_W +: REG_W];
  assign r_lba1     = regs_flat[3*REG_W +: REG_W];
  assign r_lba2     = regs_flat[4*REG_W +: REG_W];
  assign r_devhead  = regs_flat[5*REG_W +: REG_W];
  assign tf_lba     = {r_devhead[3:0], r_lba2, r_lba1, r_lba0};

  ata_tf_status #(.REG_W(REG_W)) u_status (
    .clk(clk), .rst(rst), .soft_reset(soft_reset_out), .cmd_go(cmd_go),
    .done(core_done), .done_err(core_err), .done_code(core_err_code),
    .status_rd(status_rd), .irq_mask(irq_mask_q), .selected(selected),
    .busy(busy), .err(err), .pend(pend), .irq(irq_out), .err_reg(err_reg));

  // control byte: accepted in every state
  always_ff @(posedge clk) begin
    if (rst) begin
      soft_reset_out <= 1'b0;
      irq_mask_q     <= 1'b0;
    end else if (wr && sel == SEL_ALTCTL) begin
      soft_reset_out <= wdata[CTL_SOFT_RESET];
      irq_mask_q     <= wdata[CTL_IRQ_MASK];
    end
  end

  always_comb begin
    status_byte           = '0;
    status_byte[ST_BUSY]  = busy;
    status_byte[ST_READY] = ~soft_reset_out;
    status_byte[ST_DREQ]  = core_drq & ~busy;
    status_byte[ST_ERR]   = err;
  end

  assign drvaddr = {{(REG_W-6){1'b1}}, ~r_devhead[3:0], ~dev_id_strap, dev_id_strap};

  always_comb begin
    case (sel)
      SEL_DATA:               rd_mux = dport_rd_data;
      SEL_ERRFEAT:            rd_mux = DATA_W'(err_reg);
      SEL_COUNT:              rd_mux = DATA_W'(tf_count);
      SEL_LBA0:               rd_mux = DATA_W'(r_lba0);
      SEL_LBA1:               rd_mux = DATA_W'(r_lba1);
      SEL_LBA2:               rd_mux = DATA_W'(r_lba2);
      SEL_DEVHEAD:            rd_mux = DATA_W'(r_devhead);
      SEL_STATCMD, SEL_ALTCTL: rd_mux = DATA_W'(status_byte);
      SEL_DRVADDR:            rd_mux = DATA_W'(drvaddr);
      default:                rd_mux = '0;
    endcase
    if (!selected) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0; cmd_valid <= 1'b0; cmd_opcode <= '0;
      dport_wr_valid <= 1'b0; dport_wr_data <= '0; dport_rd_req <= 1'b0;
    end else begin
      if (rd) rdata <= rd_mux;
      cmd_valid      <= cmd_go;
      if (cmd_go) cmd_opcode <= wdata[REG_W-1:0];
      dport_wr_valid <= wr && sel == SEL_DATA && selected;
      if (wr && sel == SEL_DATA && selected) dport_wr_data <= wdata;
      dport_rd_req   <= rd && sel == SEL_DATA && selected;
    end
  end

  assert_cmd_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_COUNT && busy && !soft_reset_out) |=> $stable(tf_count));
  assert_deselected_no_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_STATCMD && !selected) |=> !cmd_valid);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(!irq_mask_q && selected));
  assert_alt_read_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_ALTCTL && pend && !soft_reset_out) |=> pend);
endmodule

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 0, acc_write = 0, ctlblk_sel_n = 1, cmdblk_sel_n = 1;
  logic [2:0] reg_addr = '0;
  logic [15:0] wdata = '0, rdata, dport_wr_data, dport_rd_data = '0;
  logic dev_id_strap = 0, cmd_valid, core_done = 0, core_err = 0, core_drq = 0;
  logic [7:0] cmd_opcode, tf_feature, tf_count, core_err_code = '0;
  logic [27:0] tf_lba;
  logic soft_reset_out, irq_out, dport_wr_valid, dport_rd_req;
  int n_run = 0, n_fail = 0;
  bit fin = 0;

  always #4 clk = ~clk;

  ata_taskfile_regs u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .ctlblk_sel_n(ctlblk_sel_n), .cmdblk_sel_n(cmdblk_sel_n), .reg_addr(reg_addr),
    .wdata(wdata), .rdata(rdata), .dev_id_strap(dev_id_strap),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .tf_feature(tf_feature),
    .tf_count(tf_count), .tf_lba(tf_lba), .core_done(core_done),
    .core_err(core_err), .core_err_code(core_err_code), .core_drq(core_drq),
    .soft_reset_out(soft_reset_out), .irq_out(irq_out),
    .dport_wr_valid(dport_wr_valid), .dport_wr_data(dport_wr_data),
    .dport_rd_req(dport_rd_req), .dport_rd_data(dport_rd_data));

  // {ctlblk_sel_n, cmdblk_sel_n, addr, write, wdata, expected read}
  localparam logic [37:0] VEC [15] = '{
    {1'b1, 1'b0, 3'd2, 1'b1, 16'hA505, 16'h0000},
    {1'b1, 1'b0, 3'd3, 1'b1, 16'h0011, 16'h0000},
    {1'b1, 1'b0, 3'd4, 1'b1, 16'h0022, 16'h0000},
    {1'b1, 1'b0, 3'd5, 1'b1, 16'h0033, 16'h0000},
    {1'b1, 1'b0, 3'd6, 1'b1, 16'h00E3, 16'h0000},
    {1'b1, 1'b0, 3'd1, 1'b1, 16'h0044, 16'h0000},
    {1'b1, 1'b0, 3'd2, 1'b0, 16'h0000, 16'h0005},
    {1'b1, 1'b0, 3'd3, 1'b0, 16'h0000, 16'h0011},
    {1'b1, 1'b0, 3'd4, 1'b0, 16'h0000, 16'h0022},
    {1'b1, 1'b0, 3'd5, 1'b0, 16'h0000, 16'h0033},
    {1'b1, 1'b0, 3'd6, 1'b0, 16'h0000, 16'h00E3},
    {1'b1, 1'b0, 3'd1, 1'b0, 16'h0000, 16'h0001},   // R3: error, not feature
    {1'b1, 1'b0, 3'd7, 1'b0, 16'h0000, 16'h0040},
    {1'b0, 1'b1, 3'd6, 1'b0, 16'h0000, 16'h0040},   // R2 alternate status
    {1'b0, 1'b1, 3'd7, 1'b0, 16'h0000, 16'h00F2}    // R2 drive address
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(input logic c1, input logic c0, input logic [2:0] a,
                     input logic w, input logic [15:0] d);
    ctlblk_sel_n = c1; cmdblk_sel_n = c0; reg_addr = a; acc_write = w; wdata = d;
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; ctlblk_sel_n = 1'b1; cmdblk_sel_n = 1'b1;
  endtask

  task automatic rd_cmd(input logic [2:0] a);  acc(1'b1, 1'b0, a, 1'b0, 16'h0); endtask
  task automatic wr_cmd(input logic [2:0] a, input logic [15:0] d); acc(1'b1, 1'b0, a, 1'b1, d); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic finish_core(input logic e, input logic [7:0] code);
    core_done = 1'b1; core_err = e; core_err_code = code;
    @(negedge clk);
    core_done = 1'b0; core_err = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R13 reset state
    chk("R13 irq", {15'h0, irq_out}, 16'h0);
    chk("R13 cmd_valid", {15'h0, cmd_valid}, 16'h0);
    chk("R13 soft reset", {15'h0, soft_reset_out}, 16'h0);
    rd_cmd(3'd7); chk("R13 status", rdata, 16'h0040);
    rd_cmd(3'd2); chk("R13 count", rdata, 16'h0001);
    rd_cmd(3'd3); chk("R13 lba0", rdata, 16'h0001);
    rd_cmd(3'd1); chk("R13 error", rdata, 16'h0001);

    // R1 table walk
    for (int i = 0; i < 15; i++) begin
      acc(VEC[i][37], VEC[i][36], VEC[i][35:33], VEC[i][32], VEC[i][31:16]);
      if (!VEC[i][32]) chk("R1 table", rdata, VEC[i][15:0]);
    end
    chk("R1 lba out", {4'h0, tf_lba[27:16]}, 16'h0333);
    chk("R3 feature out", {8'h0, tf_feature}, 16'h0044);

    // R2 unmapped selects
    acc(1'b0, 1'b0, 3'd7, 1'b0, 16'h0); chk("R2 both selects", rdata, 16'h0000);
    acc(1'b1, 1'b1, 3'd2, 1'b0, 16'h0); chk("R2 no select", rdata, 16'h0000);

    // R12 data port
    wr_cmd(3'd0, 16'hBEEF);
    chk("R12 wr valid", {15'h0, dport_wr_valid}, 16'h1);
    chk("R12 wr data", dport_wr_data, 16'hBEEF);
    idle(1); chk("R12 wr pulse", {15'h0, dport_wr_valid}, 16'h0);
    dport_rd_data = 16'h1234;
    rd_cmd(3'd0);
    chk("R12 rd data", rdata, 16'h1234);
    chk("R12 rd req", {15'h0, dport_rd_req}, 16'h1);

    // R6 command
    wr_cmd(3'd7, 16'h00C8);
    chk("R6 cmd pulse", {15'h0, cmd_valid}, 16'h1);
    chk("R6 opcode", {8'h0, cmd_opcode}, 16'h00C8);
    idle(1); chk("R6 one cycle", {15'h0, cmd_valid}, 16'h0);
    rd_cmd(3'd7); chk("R6 busy status", rdata, 16'h00C0);

    // R7 writes while busy
    wr_cmd(3'd2, 16'h0077);
    rd_cmd(3'd2); chk("R7 count kept", rdata, 16'h0005);
    wr_cmd(3'd7, 16'h0030);
    chk("R7 second cmd", {15'h0, cmd_valid}, 16'h0);
    core_drq = 1'b1;
    rd_cmd(3'd7); chk("R5 dreq masked by busy", rdata, 16'h00C0);
    core_drq = 1'b0;

    // R8 / R9 / R10 completion with error
    finish_core(1'b1, 8'h04);
    idle(1); chk("R9 irq raised", {15'h0, irq_out}, 16'h1);
    acc(1'b0, 1'b1, 3'd6, 1'b0, 16'h0); chk("R10 alt status", rdata, 16'h0041);
    idle(1); chk("R10 alt keeps irq", {15'h0, irq_out}, 16'h1);
    rd_cmd(3'd1); chk("R8 error code", rdata, 16'h0004);
    rd_cmd(3'd7); chk("R8 status err", rdata, 16'h0041);
    idle(1); chk("R10 status clears irq", {15'h0, irq_out}, 16'h0);

    // R8 done while idle
    finish_core(1'b1, 8'h09);
    idle(1); chk("R8 idle done irq", {15'h0, irq_out}, 16'h0);
    rd_cmd(3'd1); chk("R8 idle done error", rdata, 16'h0004);
    core_drq = 1'b1;
    rd_cmd(3'd7); chk("R5 dreq", rdata, 16'h0049);
    core_drq = 1'b0;

    // R6 clears error; R9 mask
    wr_cmd(3'd7, 16'h0020);
    rd_cmd(3'd7); chk("R6 err cleared", rdata, 16'h00C0);
    finish_core(1'b0, 8'h00);
    idle(1); chk("R9 irq ok", {15'h0, irq_out}, 16'h1);
    acc(1'b0, 1'b1, 3'd6, 1'b1, 16'h0002);
    idle(1); chk("R9 masked", {15'h0, irq_out}, 16'h0);
    acc(1'b0, 1'b1, 3'd6, 1'b1, 16'h0000);
    idle(1); chk("R9 unmasked", {15'h0, irq_out}, 16'h1);

    // R4 device selection
    wr_cmd(3'd6, 16'h00F0);
    idle(1); chk("R4 irq deselected", {15'h0, irq_out}, 16'h0);
    rd_cmd(3'd7); chk("R4 status reads 0", rdata, 16'h0000);
    wr_cmd(3'd7, 16'h00EC); chk("R4 cmd ignored", {15'h0, cmd_valid}, 16'h0);
    wr_cmd(3'd0, 16'h5555); chk("R4 data ignored", {15'h0, dport_wr_valid}, 16'h0);
    wr_cmd(3'd6, 16'h00E0);
    idle(1); chk("R4 pend survives", {15'h0, irq_out}, 16'h1);
    dev_id_strap = 1'b1;
    acc(1'b0, 1'b1, 3'd6, 1'b0, 16'h0); chk("R4 strap", rdata, 16'h0000);
    dev_id_strap = 1'b0;
    rd_cmd(3'd7); chk("R10 status", rdata, 16'h0040);
    idle(1); chk("R10 cleared", {15'h0, irq_out}, 16'h0);

    // R11 soft reset
    acc(1'b0, 1'b1, 3'd6, 1'b1, 16'h0004);
    idle(1);
    chk("R11 out", {15'h0, soft_reset_out}, 16'h1);
    rd_cmd(3'd7); chk("R11 status", rdata, 16'h0080);
    wr_cmd(3'd2, 16'h0009);
    rd_cmd(3'd2); chk("R11 count held", rdata, 16'h0001);
    acc(1'b0, 1'b1, 3'd6, 1'b1, 16'h0000);
    idle(1);
    rd_cmd(3'd7); chk("R11 released", rdata, 16'h0040);
    chk("R11 out low", {15'h0, soft_reset_out}, 16'h0);
    rd_cmd(3'd6); chk("R11 devhead reset", rdata, 16'h0000);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule